// File: doc/BRIEF.md
# Configuration Transaction Engine

This block runs single configuration transactions toward board-level resources through three memory-mapped registers: a data register, a control register and a status register. Software first loads the data register when it wants to write. It then writes a packed control word. That word picks the controller, the function, the site, the stack position and the device, and says whether to read or write. If the launch bit is set in that write, the engine checks the target and carries out the operation against its internal oscillator table, its voltage values or its system request outputs. It finishes within the same bus write.

Oscillator settings live in a register table. The table holds six main-board entries and a parameterised number of daughter-board entries, and both groups have defined reset values. Voltage values are constants: one fixed value for the main board and a parameter table for the daughter board. Shutdown and reboot requests leave the block as single-cycle pulses. A parameter removes the register set entirely, for build variants that do not carry it.

Top module: `cfgx_engine`

## Requirements
- R1: The control word is decoded as launch = bit 31, write (1) / read (0) = bit 30, controller index = bits 29:26, function code = bits 25:20, site = bits 17:16, position = bits 15:12, device = bits 11:0. The register offsets are data 0xA0, control 0xA4 and status 0xA8.
- R2: Reading the control register always returns zero in bit 31 and in bits 19:18. All other bits read back as last written.
- R3: After reset, the data, control and status registers read 0. A launch that succeeds sets status to 1, where bit 0 means done and bit 1 means error.
- R4: A launch sets status to 3 and leaves data unchanged when the target is unsupported. The target is unsupported when the controller index is not 0, when the position is not 0, or when the site is 2 or 3. Site 0 is the main board and site 1 is the daughter board.
- R5: Function 1 reads or writes oscillator entries. Main-board devices 0 to 5 reset to 50000000, 23750000, 24000000, 24000000, 24000000 and 24000000. Daughter-board devices below DB_OSC_NUM reset to DB_OSC_RESET. Any other device gives an error.
- R6: Function 2 is read-only. On the main board, device 0 returns 3300000. On the daughter board, devices below DB_VOLT_NUM return DB_VOLT_VAL. Every other case, including any write, gives an error.
- R7: A read that succeeds places its result in the data register. A write takes its operand from the data register.
- R8: A write launch of function 8 or 9 to main-board device 0 produces a one-cycle pulse on shutdown_req or reboot_req in the cycle after the launch. Write launches of functions 7 and 11 to main-board device 0 succeed and have no effect. All other uses of functions 7, 8, 9 and 11, and all other function codes, give an error and produce no pulse.
- R9: A write to the status register stores only bits 1:0 of the written value.
- R10: With CFG_PRESENT = 0, all three registers read 0, writes are ignored, and no request pulse is ever produced.
- R11: A control write with bit 31 clear stores the fields of the word. It does not change the status register or the data register.
- R12: Offsets outside the three registers read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte offset of the register access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| shutdown_req | output | 1 | One-cycle shutdown request pulse |
| reboot_req | output | 1 | One-cycle reboot request pulse |

## Verification
The bench builds the engine with three daughter-board oscillators and two daughter-board voltage entries. Devices 0 to 7 are drawn at random, so every site has both in-range and out-of-range devices, including the daughter-board boundary at index 3 for oscillators and index 2 for voltages. A second instance is built with CFG_PRESENT = 0 and receives the same bus traffic, which tests the absent variant side by side with the present one.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

    localparam int WORD_W     = 32;
    localparam int MB_OSC_NUM = 6;
    localparam int DEV_W      = 12;

    localparam int OFS_DATA = 'hA0;
    localparam int OFS_CTRL = 'hA4;
    localparam int OFS_STAT = 'hA8;

    localparam logic [5:0] FN_OSC     = 6'd1;
    localparam logic [5:0] FN_VOLT    = 6'd2;
    localparam logic [5:0] FN_VIDMUX  = 6'd7;
    localparam logic [5:0] FN_SHUT    = 6'd8;
    localparam logic [5:0] FN_BOOT    = 6'd9;
    localparam logic [5:0] FN_DISPSEL = 6'd11;

    localparam logic [31:0] MB_VOLT_VAL = 32'd3300000;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_DATA,
        SEL_CTRL,
        SEL_STAT
    } reg_sel_e;

    // Packed control word, bit 31 first.
    typedef struct packed {
        logic             launch;
        logic             write;
        logic [3:0]       ctl;
        logic [5:0]       fn;
        logic [1:0]       rsvd;
        logic [1:0]       site;
        logic [3:0]       pos;
        logic [DEV_W-1:0] dev;
    } cfg_word_t;

    // Outcome of decoding one launched word.
    typedef struct packed {
        logic ok;
        logic osc_rd;
        logic osc_wr;
        logic volt_rd;
        logic shut;
        logic boot;
    } cfg_action_t;

    function automatic logic [31:0] mb_osc_reset(input int idx);
        case (idx)
            0:       return 32'd50000000;
            1:       return 32'd23750000;
            default: return 32'd24000000;
        endcase
    endfunction

    // Clear the launch bit and the reserved bits before storing.
    function automatic cfg_word_t scrub_word(input logic [31:0] raw);
        cfg_word_t w;
        w        = cfg_word_t'(raw);
        w.launch = 1'b0;
        w.rsvd   = 2'b00;
        return w;
    endfunction

endpackage

// File: rtl/cfgx_decode.sv
module cfgx_decode
    import cfgx_pkg::*;
#(
    parameter int DB_OSC_NUM  = 2,
    parameter int DB_VOLT_NUM = 2
) (
    input  cfg_word_t   word,
    output cfg_action_t act
);

    logic target_ok;
    logic on_mb;
    logic on_db;
    logic dev_zero;
    logic osc_hit;
    logic volt_hit;
    logic mb_ctl_ok;
    logic unused_fields;

    assign unused_fields = &{1'b0, word.launch, word.rsvd};

    always_comb begin
        target_ok = (word.ctl == 4'd0) && (word.pos == 4'd0) && !word.site[1];
        on_mb     = target_ok && (word.site[0] == 1'b0);
        on_db     = target_ok && (word.site[0] == 1'b1);
        dev_zero  = (word.dev == '0);
        osc_hit   = (on_mb && (32'(word.dev) < 32'(MB_OSC_NUM))) ||
                    (on_db && (32'(word.dev) < 32'(DB_OSC_NUM)));
        volt_hit  = (on_mb && dev_zero) ||
                    (on_db && (32'(word.dev) < 32'(DB_VOLT_NUM)));
        mb_ctl_ok = on_mb && dev_zero && word.write;

        act = '0;
        case (word.fn)
            FN_OSC: begin
                act.ok     = osc_hit;
                act.osc_rd = osc_hit && !word.write;
                act.osc_wr = osc_hit && word.write;
            end
            FN_VOLT: begin
                act.ok      = volt_hit && !word.write;
                act.volt_rd = volt_hit && !word.write;
            end
            FN_VIDMUX, FN_DISPSEL: begin
                act.ok = mb_ctl_ok;
            end
            FN_SHUT: begin
                act.ok   = mb_ctl_ok;
                act.shut = mb_ctl_ok;
            end
            FN_BOOT: begin
                act.ok   = mb_ctl_ok;
                act.boot = mb_ctl_ok;
            end
            default: act = '0;
        endcase
    end

endmodule

// File: rtl/cfgx_osc_table.sv
module cfgx_osc_table
    import cfgx_pkg::*;
#(
    parameter int                       DB_OSC_NUM   = 2,
    parameter logic [DB_OSC_NUM*32-1:0] DB_OSC_RESET = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             db_sel,
    input  logic [DEV_W-1:0] dev,
    input  logic             wr_en,
    input  logic [31:0]      wr_val,
    output logic [31:0]      rd_val
);

    localparam int TOT   = MB_OSC_NUM + DB_OSC_NUM;
    localparam int IDX_W = $clog2(TOT);

    logic [31:0]      osc_q [TOT];
    logic [31:0]      flat32;
    logic [IDX_W-1:0] flat;

    always_comb begin
        flat32 = db_sel ? (32'(dev) + 32'(MB_OSC_NUM)) : 32'(dev);
        flat   = flat32[IDX_W-1:0];
    end

    for (genvar i = 0; i < TOT; i++) begin : g_ent
        logic [31:0] rst_val;
        if (i < MB_OSC_NUM) begin : g_mb
            assign rst_val = mb_osc_reset(i);
        end else begin : g_db
            assign rst_val = DB_OSC_RESET[(i-MB_OSC_NUM)*32 +: 32];
        end

        always_ff @(posedge clk) begin
            if (rst)
                osc_q[i] <= rst_val;
            else if (wr_en && (flat == IDX_W'(i)))
                osc_q[i] <= wr_val;
        end
    end

    always_comb begin
        rd_val = '0;
        for (int k = 0; k < TOT; k++)
            if (flat == IDX_W'(k))
                rd_val = osc_q[k];
    end

endmodule

// File: rtl/cfgx_volt_rom.sv
module cfgx_volt_rom
    import cfgx_pkg::*;
#(
    parameter int                        DB_VOLT_NUM = 2,
    parameter logic [DB_VOLT_NUM*32-1:0] DB_VOLT_VAL = '0
) (
    input  logic             db_sel,
    input  logic [DEV_W-1:0] dev,
    output logic [31:0]      value
);

    always_comb begin
        value = '0;
        if (!db_sel) begin
            value = MB_VOLT_VAL;
        end else begin
            for (int k = 0; k < DB_VOLT_NUM; k++)
                if (32'(dev) == 32'(k))
                    value = DB_VOLT_VAL[k*32 +: 32];
        end
    end

endmodule

// File: rtl/cfgx_engine.sv
module cfgx_engine
    import cfgx_pkg::*;
#(
    parameter bit                        CFG_PRESENT  = 1'b1,
    parameter int                        ADDR_W       = 12,
    parameter int                        DB_OSC_NUM   = 2,
    parameter int                        DB_VOLT_NUM  = 2,
    parameter logic [DB_OSC_NUM*32-1:0]  DB_OSC_RESET = {32'd45000000, 32'd60000000},
    parameter logic [DB_VOLT_NUM*32-1:0] DB_VOLT_VAL  = {32'd1800000, 32'd1000000}
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              shutdown_req,
    output logic              reboot_req
);

    reg_sel_e    sel;
    cfg_word_t   wr_word;
    cfg_word_t   ctrl_q;
    cfg_action_t act;
    logic [31:0] data_q;
    logic [1:0]  stat_q;
    logic [31:0] osc_val;
    logic [31:0] volt_val;
    logic        launch;

    always_comb begin
        if (!CFG_PRESENT)                      sel = SEL_NONE;
        else if (addr == ADDR_W'(OFS_DATA))    sel = SEL_DATA;
        else if (addr == ADDR_W'(OFS_CTRL))    sel = SEL_CTRL;
        else if (addr == ADDR_W'(OFS_STAT))    sel = SEL_STAT;
        else                                   sel = SEL_NONE;
    end

    assign wr_word = scrub_word(wdata);
    assign launch  = wr_en && (sel == SEL_CTRL) && wdata[31];

    cfgx_decode #(
        .DB_OSC_NUM (DB_OSC_NUM),
        .DB_VOLT_NUM(DB_VOLT_NUM)
    ) u_decode (
        .word(wr_word),
        .act (act)
    );

    cfgx_osc_table #(
        .DB_OSC_NUM  (DB_OSC_NUM),
        .DB_OSC_RESET(DB_OSC_RESET)
    ) u_osc (
        .clk   (clk),
        .rst   (rst),
        .db_sel(wr_word.site[0]),
        .dev   (wr_word.dev),
        .wr_en (launch && act.osc_wr),
        .wr_val(data_q),
        .rd_val(osc_val)
    );

    cfgx_volt_rom #(
        .DB_VOLT_NUM(DB_VOLT_NUM),
        .DB_VOLT_VAL(DB_VOLT_VAL)
    ) u_volt (
        .db_sel(wr_word.site[0]),
        .dev   (wr_word.dev),
        .value (volt_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q       <= '0;
            ctrl_q       <= '0;
            stat_q       <= '0;
            shutdown_req <= 1'b0;
            reboot_req   <= 1'b0;
        end else begin
            shutdown_req <= 1'b0;
            reboot_req   <= 1'b0;
            if (wr_en) begin
                case (sel)
                    SEL_DATA: data_q <= wdata;
                    SEL_CTRL: begin
                        ctrl_q <= wr_word;
                        if (launch) begin
                            stat_q       <= {~act.ok, 1'b1};
                            shutdown_req <= act.shut;
                            reboot_req   <= act.boot;
                            if (act.osc_rd)
                                data_q <= osc_val;
                            else if (act.volt_rd)
                                data_q <= volt_val;
                        end
                    end
                    SEL_STAT: stat_q <= wdata[1:0];
                    default:  ;
                endcase
            end
        end
    end

    always_comb begin
        case (sel)
            SEL_DATA: rdata = data_q;
            SEL_CTRL: rdata = ctrl_q;
            SEL_STAT: rdata = {30'd0, stat_q};
            default:  rdata = '0;
        endcase
    end

    if (CFG_PRESENT) begin : g_chk
        AST_LAUNCH_DONE: assert property (@(posedge clk) disable iff (rst)
            (wr_en && addr == ADDR_W'(OFS_CTRL) && wdata[31]) |=> stat_q[0]); // R3
        AST_BAD_CTL_ERR: assert property (@(posedge clk) disable iff (rst)
            (wr_en && addr == ADDR_W'(OFS_CTRL) && wdata[31] && wdata[29:26] != 4'd0)
            |=> (stat_q == 2'b11)); // R4
        AST_ERR_KEEPS_DATA: assert property (@(posedge clk) disable iff (rst)
            (launch && !act.ok) |=> $stable(data_q)); // R4
        AST_STAT_LOW2: assert property (@(posedge clk) disable iff (rst)
            (wr_en && addr == ADDR_W'(OFS_STAT)) |=> (stat_q == $past(wdata[1:0]))); // R9
        AST_CTRL_CLEAN: assert property (@(posedge clk) disable iff (rst)
            (addr == ADDR_W'(OFS_CTRL)) |-> (rdata[31] == 1'b0 && rdata[19:18] == 2'b00)); // R2
        AST_SHUT_PULSE: assert property (@(posedge clk) disable iff (rst)
            shutdown_req |=> !shutdown_req); // R8
        AST_BOOT_PULSE: assert property (@(posedge clk) disable iff (rst)
            reboot_req |=> !reboot_req); // R8
        AST_REQ_EXCL: assert property (@(posedge clk) disable iff (rst)
            !(shutdown_req && reboot_req)); // R8
    end else begin : g_chk_absent
        AST_ABSENT_QUIET: assert property (@(posedge clk) disable iff (rst)
            (rdata == 32'd0) && !shutdown_req && !reboot_req); // R10
    end

endmodule

// File: tb/tb_cfgx_engine.sv
module tb_cfgx_engine;

    localparam int ADDR_W = 12;
    localparam int DBO    = 3;
    localparam int DBV    = 2;
    localparam logic [DBO*32-1:0] OSC_RST = {32'd33000000, 32'd22000000, 32'd11000000};
    localparam logic [DBV*32-1:0] VOLT_V  = {32'd1200000, 32'd900000};
    localparam int A_DATA = 'hA0;
    localparam int A_CTRL = 'hA4;
    localparam int A_STAT = 'hA8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata, rdata_abs;
    logic              shut, boot, shut_abs, boot_abs;

    int checks = 0;
    int errors = 0;
    logic last_shut, last_boot, last_shut_abs, last_boot_abs;

    logic [31:0] m_mb  [6];
    logic [31:0] m_db  [DBO];
    logic [31:0] m_dv  [DBV];
    logic [31:0] m_data;
    logic [1:0]  m_stat;

    always #5 clk = ~clk;

    cfgx_engine #(
        .CFG_PRESENT(1'b1), .ADDR_W(ADDR_W), .DB_OSC_NUM(DBO), .DB_VOLT_NUM(DBV),
        .DB_OSC_RESET(OSC_RST), .DB_VOLT_VAL(VOLT_V)
    ) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .shutdown_req(shut), .reboot_req(boot)
    );

    cfgx_engine #(
        .CFG_PRESENT(1'b0), .ADDR_W(ADDR_W), .DB_OSC_NUM(DBO), .DB_VOLT_NUM(DBV),
        .DB_OSC_RESET(OSC_RST), .DB_VOLT_VAL(VOLT_V)
    ) dut_absent (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata_abs), .shutdown_req(shut_abs), .reboot_req(boot_abs)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic bus_write(input int a, input logic [31:0] d);
        wr_en = 1'b1;
        addr  = ADDR_W'(a);
        wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en         = 1'b0;
        last_shut     = shut;
        last_boot     = boot;
        last_shut_abs = shut_abs;
        last_boot_abs = boot_abs;
    endtask

    task automatic bus_read(input int a, output logic [31:0] d, output logic [31:0] d_abs);
        wr_en = 1'b0;
        addr  = ADDR_W'(a);
        #1;
        d     = rdata;
        d_abs = rdata_abs;
    endtask

    task automatic expect_reg(input string req, input int a, input logic [31:0] exp);
        logic [31:0] v, va;
        bus_read(a, v, va);
        check(req, v, exp);
    endtask

    task automatic set_data(input logic [31:0] d);
        bus_write(A_DATA, d);
        m_data = d;
    endtask

    task automatic launch(input bit wr, input int ctl, input int fn, input int site,
                          input int pos, input int dev, input string req);
        logic [31:0] word;
        logic [31:0] val;
        bit ok, eshut, eboot, tgt;
        word  = {1'b1, wr, 4'(ctl), 6'(fn), 2'b11, 2'(site), 4'(pos), 12'(dev)};
        ok    = 0;
        eshut = 0;
        eboot = 0;
        val   = m_data;
        tgt   = (ctl == 0) && (pos == 0) && (site < 2);
        if (tgt) begin
            case (fn)
                1: begin
                    if (site == 0 && dev < 6) begin
                        ok = 1;
                        if (wr) m_mb[dev] = m_data; else val = m_mb[dev];
                    end else if (site == 1 && dev < DBO) begin
                        ok = 1;
                        if (wr) m_db[dev] = m_data; else val = m_db[dev];
                    end
                end
                2: if (!wr) begin
                    if (site == 0 && dev == 0) begin ok = 1; val = 32'd3300000; end
                    else if (site == 1 && dev < DBV) begin ok = 1; val = m_dv[dev]; end
                end
                7, 11: ok = wr && site == 0 && dev == 0;
                8: begin ok = wr && site == 0 && dev == 0; eshut = ok; end
                9: begin ok = wr && site == 0 && dev == 0; eboot = ok; end
                default: ok = 0;
            endcase
        end
        m_stat = ok ? 2'd1 : 2'd3;
        if (ok && !wr) m_data = val;
        bus_write(A_CTRL, word);
        check({req, " shutdown pulse (R8)"}, 32'(last_shut), 32'(eshut));
        check({req, " reboot pulse (R8)"}, 32'(last_boot), 32'(eboot));
        expect_reg({req, " status (R3/R4)"}, A_STAT, 32'(m_stat));
        expect_reg({req, " data (R7)"}, A_DATA, m_data);
        expect_reg({req, " ctrl readback (R1/R2)"}, A_CTRL, word & 32'h7FF3_FFFF);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v, va;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 6; i++) m_mb[i] = (i == 0) ? 32'd50000000 : (i == 1) ? 32'd23750000 : 32'd24000000;
        for (int i = 0; i < DBO; i++) m_db[i] = OSC_RST[i*32 +: 32];
        for (int i = 0; i < DBV; i++) m_dv[i] = VOLT_V[i*32 +: 32];
        m_data = 0;
        m_stat = 0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R3: reset state
        expect_reg("R3 reset data", A_DATA, 0);
        expect_reg("R3 reset ctrl", A_CTRL, 0);
        expect_reg("R3 reset status", A_STAT, 0);

        // R11 / R2: control write without launch
        bus_write(A_CTRL, 32'h7FFF_FFFF);
        expect_reg("R2 ctrl clears 19:18", A_CTRL, 32'h7FF3_FFFF);
        expect_reg("R11 status untouched", A_STAT, 0);
        expect_reg("R11 data untouched", A_DATA, 0);

        // R5: oscillator reset values, both sites
        for (int d = 0; d < 6; d++) launch(0, 0, 1, 0, 0, d, "R5 mb osc reset");
        for (int d = 0; d < DBO; d++) launch(0, 0, 1, 1, 0, d, "R5 db osc reset");
        launch(0, 0, 1, 0, 0, 6, "R5 mb osc out of range");
        launch(0, 0, 1, 1, 0, DBO, "R5 db osc out of range");

        // R7: write then read back
        set_data(32'd12345678);
        launch(1, 0, 1, 0, 0, 3, "R7 mb osc write");
        set_data(32'd0);
        launch(0, 0, 1, 0, 0, 3, "R7 mb osc readback");
        set_data(32'hCAFE0001);
        launch(1, 0, 1, 1, 0, 2, "R7 db osc write");
        launch(0, 0, 1, 1, 0, 2, "R7 db osc readback");

        // R6: voltage
        launch(0, 0, 2, 0, 0, 0, "R6 mb volt");
        launch(0, 0, 2, 1, 0, 1, "R6 db volt");
        launch(0, 0, 2, 1, 0, DBV, "R6 db volt out of range");
        launch(0, 0, 2, 0, 0, 1, "R6 mb volt dev1");
        launch(1, 0, 2, 0, 0, 0, "R6 volt write rejected");

        // R4: unsupported targets
        launch(0, 1, 1, 0, 0, 0, "R4 bad controller");
        launch(0, 0, 1, 0, 2, 0, "R4 bad position");
        launch(0, 0, 1, 2, 0, 0, "R4 site 2");
        launch(0, 0, 1, 3, 0, 0, "R4 site 3");

        // R8: system requests and no-effect functions
        launch(1, 0, 8, 0, 0, 0, "R8 shutdown");
        check("R10 absent no shutdown", 32'(last_shut_abs), 0);
        launch(1, 0, 9, 0, 0, 0, "R8 reboot");
        check("R10 absent no reboot", 32'(last_boot_abs), 0);
        launch(1, 0, 8, 0, 0, 1, "R8 shutdown wrong device");
        launch(0, 0, 9, 0, 0, 0, "R8 reboot as read");
        launch(1, 0, 9, 1, 0, 0, "R8 reboot on db");
        launch(1, 0, 7, 0, 0, 0, "R8 fn7 accepted");
        launch(1, 0, 11, 0, 0, 0, "R8 fn11 accepted");
        launch(0, 0, 11, 0, 0, 0, "R8 fn11 read rejected");
        launch(1, 0, 3, 0, 0, 0, "R8 unknown function");

        // R9: status write
        bus_write(A_STAT, 32'hFFFF_FFFE);
        m_stat = 2;
        expect_reg("R9 status low two bits", A_STAT, 2);
        bus_write(A_STAT, 32'h0000_0005);
        m_stat = 1;
        expect_reg("R9 status low two bits again", A_STAT, 1);

        // R12: unmapped offsets
        bus_write('h04, 32'hFFFF_FFFF);
        expect_reg("R12 unmapped reads zero", 'h04, 0);
        expect_reg("R12 data unchanged", A_DATA, m_data);
        expect_reg("R12 status unchanged", A_STAT, 32'(m_stat));

        // R10: absent variant
        bus_write(A_DATA, 32'h1234_5678);
        m_data = 32'h1234_5678;
        bus_write(A_STAT, 32'h3);
        m_stat = 3;
        bus_read(A_DATA, v, va); check("R10 absent data", va, 0);
        bus_read(A_CTRL, v, va); check("R10 absent ctrl", va, 0);
        bus_read(A_STAT, v, va); check("R10 absent status", va, 0);

        // R1: random transactions across the field space
        for (int n = 0; n < 300; n++) begin
            int fnsel;
            int fns [10] = '{1, 1, 2, 2, 7, 8, 9, 11, 3, 0};
            fnsel = int'($urandom_range(0, 9));
            if ($urandom_range(0, 2) == 0) set_data($urandom);
            launch($urandom_range(0, 1) == 1,
                   ($urandom_range(0, 9) == 0) ? int'($urandom_range(1, 15)) : 0,
                   fns[fnsel],
                   int'($urandom_range(0, 3)),
                   ($urandom_range(0, 9) == 0) ? int'($urandom_range(1, 15)) : 0,
                   int'($urandom_range(0, 7)),
                   "R1 random");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule